// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block watches the address phase of an I2C transfer on the target side and decides whether the transfer is meant for this node. A separate bit engine handles the pins and shifting. It hands this block whole received bytes and one-cycle strobes for START and STOP. The recognizer compares the first byte after a START, or the first two bytes in 10-bit mode, against a programmable own address. When they agree it raises a single-cycle match pulse and reports the transfer direction.

The own address sits in one right-justified 10-bit register that serves both addressing modes. An optional general-call response can be enabled. When a general call is accepted, a sticky status flag is set, and the next START clears it. The address register and the general-call enable can be written only while the software-reset input is high. Software reset also parks the sequencer and clears the status flag.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `match`, `rw_dir` and `gc_flag` are 0, the stored own address is 0 and the general-call response is disabled.
- R2: In 7-bit mode (`mode_10b`=0), a first byte after START whose bits 7:1 equal own-address bits 6:0 gives `match`=1 on the clock edge that follows the byte strobe, with `rw_dir` equal to bit 0 of that byte. Own-address bits 9:7 do not take part in the comparison.
- R3: In 10-bit mode (`mode_10b`=1), the first byte must be binary 11110 in bits 7:3 and own-address bits 9:8 in bits 2:1. The second byte must equal own-address bits 7:0. The match pulse follows the second byte, never the first alone, and `rw_dir` takes bit 0 of the first byte.
- R4: A byte that fails its comparison returns the block to idle. Every later byte is ignored until the next START.
- R5: With the general call enabled, a first byte of 0x00 in either mode produces a match with `rw_dir`=0 and sets `gc_flag`. A byte of 0x00 is never treated as an own-address match.
- R6: With the general call disabled, a first byte of 0x00 produces no match and leaves `gc_flag` at 0.
- R7: `gc_flag` stays set across STOPs and later bytes. It reads 0 on the clock edge after a START strobe.
- R8: `cfg_wr` loads `cfg_addr` and `cfg_gc_en` only while `sw_rst`=1. A write with `sw_rst`=0 has no effect.
- R9: While `sw_rst`=1 the block gives no match, clears `gc_flag` and returns to idle, so a byte after `sw_rst` falls needs a fresh START.
- R10: STOP returns the block to idle. In the same cycle, STOP outranks START, and either event strobe outranks `byte_vld`; a byte that arrives with an event strobe is dropped.
- R11: Bytes with no START before them are ignored. `match` lasts exactly one cycle, and after a match further bytes are ignored until the next START.
- R12: `rw_dir` changes only when `match` pulses and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_rst | input | 1 | Software reset; opens the configuration register and idles the block |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 10 | Own address to load, right-justified |
| cfg_gc_en | input | 1 | General-call response enable to load |
| mode_10b | input | 1 | 0 = 7-bit addressing, 1 = 10-bit addressing |
| start_evt | input | 1 | One-cycle START (or repeated START) strobe |
| stop_evt | input | 1 | One-cycle STOP strobe |
| byte_vld | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte, bit 0 = R/W position of first byte |
| match | output | 1 | One-cycle address match pulse |
| rw_dir | output | 1 | Direction of the last matched transfer, 1 = read |
| gc_flag | output | 1 | Sticky general-call-received status |

## Verification
The properties assume that the bit engine raises each strobe for a single cycle and that configuration writes come only through the ports. They make no assumption that events and bytes are kept apart, because the block defines what happens when they coincide. The directed stimulus drives every strobe for one cycle on the falling edge. On purpose, it also presents START with STOP and START with a byte in the same cycle, to exercise the priority rules. It also tries configuration writes with software reset low, to show they are refused.

// File: rtl/i2c_am_pkg.sv
// Shared constants and types for the I2C address recognizer.
// Assumes standard I2C address framing: 7-bit byte plus R/W, or 10-bit header.
package i2c_am_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned ADDR_W   = 10;
    localparam int unsigned SHORT_W  = 7;
    localparam int unsigned HI_W     = ADDR_W - BYTE_W;        // address bits in 10-bit header
    localparam int unsigned PREFIX_W = BYTE_W - 1 - HI_W;      // fixed header prefix width
    localparam logic [PREFIX_W-1:0] TEN_PREFIX = 5'b11110;
    localparam logic [BYTE_W-1:0]   GC_BYTE    = '0;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } am_state_t;
endpackage

// File: rtl/i2c_am_cfg.sv
// Own-address and general-call-enable holding register.
// Assumes software reset gates every write; writes at other times are dropped.
module i2c_am_cfg
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_gc_en,
    output logic [ADDR_W-1:0] own_addr,
    output logic              gc_en
);
    // Load new settings only while the block is held in software reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_addr <= '0;
            gc_en    <= 1'b0;
        end else if (cfg_wr && sw_rst) begin
            own_addr <= cfg_addr;
            gc_en    <= cfg_gc_en;
        end
    end
endmodule

// File: rtl/i2c_am_decode.sv
// Combinational byte classifier: general call, 7-bit hit, 10-bit header and low byte.
// Assumes byte bit 0 is the R/W position when the byte is a first address byte.
module i2c_am_decode
    import i2c_am_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              is_gc,
    output logic              hit7,
    output logic              hdr_ok,
    output logic              lo_ok
);
    // Compare the received byte against each possible address form.
    always_comb begin
        is_gc  = (rx_byte == GC_BYTE);
        hit7   = (rx_byte[BYTE_W-1:1] == own_addr[SHORT_W-1:0]);
        hdr_ok = (rx_byte[BYTE_W-1 -: PREFIX_W] == TEN_PREFIX) &&
                 (rx_byte[HI_W:1] == own_addr[ADDR_W-1 -: HI_W]);
        lo_ok  = (rx_byte == own_addr[BYTE_W-1:0]);
    end
endmodule

// File: rtl/i2c_am_seq.sv
// Address-phase sequencer: tracks START/STOP and address bytes, issues match and direction.
// Assumes event strobes last one cycle; STOP outranks START, both outrank a byte.
module i2c_am_seq
    import i2c_am_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_rst,
    input  logic       mode_10b,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic       byte_vld,
    input  logic       rw_bit,
    input  logic       gc_en,
    input  logic       is_gc,
    input  logic       hit7,
    input  logic       hdr_ok,
    input  logic       lo_ok,
    output logic       match,
    output logic       rw_dir,
    output logic       gc_hit
);
    am_state_t state_q, state_d;
    logic      rw_pend_q;
    logic      cap_rw;
    logic      hit;
    logic      rw_new;

    // Decide next state and whether this cycle's byte completes a match.
    always_comb begin
        state_d = state_q;
        hit     = 1'b0;
        gc_hit  = 1'b0;
        cap_rw  = 1'b0;
        rw_new  = rw_pend_q;
        if (sw_rst || stop_evt) begin
            state_d = ST_IDLE;
        end else if (start_evt) begin
            state_d = ST_FIRST;
        end else if (byte_vld) begin
            unique case (state_q)
                ST_FIRST: begin
                    state_d = ST_IDLE;
                    if (is_gc) begin
                        hit    = gc_en;
                        gc_hit = gc_en;
                        rw_new = 1'b0;
                    end else if (mode_10b) begin
                        if (hdr_ok) begin
                            state_d = ST_SECOND;
                            cap_rw  = 1'b1;
                        end
                    end else begin
                        hit    = hit7;
                        rw_new = rw_bit;
                    end
                end
                ST_SECOND: begin
                    state_d = ST_IDLE;
                    hit     = lo_ok;
                    rw_new  = rw_pend_q;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Advance the state and hold the header direction for the second byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rw_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cap_rw) rw_pend_q <= rw_bit;
        end
    end

    // Register the match pulse and update direction only on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match  <= 1'b0;
            rw_dir <= 1'b0;
        end else begin
            match <= hit;
            if (hit) rw_dir <= rw_new;
        end
    end
endmodule

// File: rtl/i2c_am_gcflag.sv
// Sticky general-call-received flag, cleared by START or software reset.
// Assumes the set request never coincides with a clear request.
module i2c_am_gcflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    // Hold the flag until a clearing event arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (clr_req) flag <= 1'b0;
        else if (set_req) flag <= 1'b1;
    end
endmodule

// File: rtl/i2c_addr_match.sv
// Top of the I2C target address recognizer: config register, byte classifier,
// sequencer and general-call flag. Assumes a bit engine delivering bytes and strobes.
module i2c_addr_match
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_gc_en,
    input  logic              mode_10b,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              match,
    output logic              rw_dir,
    output logic              gc_flag
);
    logic [ADDR_W-1:0] own_addr_q;
    logic              gc_en_q;
    logic              is_gc, hit7, hdr_ok, lo_ok;
    logic              gc_hit;

    i2c_am_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst    (sw_rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_gc_en (cfg_gc_en),
        .own_addr  (own_addr_q),
        .gc_en     (gc_en_q)
    );

    i2c_am_decode u_dec (
        .rx_byte  (byte_data),
        .own_addr (own_addr_q),
        .is_gc    (is_gc),
        .hit7     (hit7),
        .hdr_ok   (hdr_ok),
        .lo_ok    (lo_ok)
    );

    i2c_am_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst    (sw_rst),
        .mode_10b  (mode_10b),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .byte_vld  (byte_vld),
        .rw_bit    (byte_data[0]),
        .gc_en     (gc_en_q),
        .is_gc     (is_gc),
        .hit7      (hit7),
        .hdr_ok    (hdr_ok),
        .lo_ok     (lo_ok),
        .match     (match),
        .rw_dir    (rw_dir),
        .gc_hit    (gc_hit)
    );

    i2c_am_gcflag u_gcf (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (gc_hit),
        .clr_req (start_evt || sw_rst),
        .flag    (gc_flag)
    );
endmodule

// File: rtl/i2c_addr_match_chk.sv
// Property checker for the address recognizer, bound to the top module.
module i2c_addr_match_chk
    import i2c_am_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sw_rst,
    input logic              start_evt,
    input logic              stop_evt,
    input logic              byte_vld,
    input logic              match,
    input logic              rw_dir,
    input logic              gc_flag,
    input logic [ADDR_W-1:0] own_addr_q,
    input logic              gc_en_q
);
    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !match);
    p_needs_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> !match);
    p_start_clears_gc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !gc_flag);
    p_gc_with_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gc_flag) |-> (match && !rw_dir));
    p_gc_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gc_flag) |-> gc_en_q);
    p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rst |=> ($stable(own_addr_q) && $stable(gc_en_q)));
    p_swrst_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (!match && !gc_flag));
    p_stop_no_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !match);
    p_rw_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !match |-> $stable(rw_dir));
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_rst     (sw_rst),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .byte_vld   (byte_vld),
    .match      (match),
    .rw_dir     (rw_dir),
    .gc_flag    (gc_flag),
    .own_addr_q (own_addr_q),
    .gc_en_q    (gc_en_q)
);

// File: tb/i2c_addr_match_bench.sv
`timescale 1ns/1ps
module i2c_addr_match_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_rst = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [9:0] cfg_addr = '0;
    logic       cfg_gc_en = 1'b0;
    logic       mode_10b = 1'b0;
    logic       start_evt = 1'b0;
    logic       stop_evt = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       match, rw_dir, gc_flag;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    i2c_addr_match u_i2c_addr_match (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_gc_en(cfg_gc_en), .mode_10b(mode_10b),
        .start_evt(start_evt), .stop_evt(stop_evt), .byte_vld(byte_vld),
        .byte_data(byte_data), .match(match), .rw_dir(rw_dir), .gc_flag(gc_flag)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [9:0] a, input logic g);
        @(negedge clk); sw_rst = 1'b1; cfg_wr = 1'b1; cfg_addr = a; cfg_gc_en = g;
        @(negedge clk); cfg_wr = 1'b0; sw_rst = 1'b0;
    endtask

    task automatic start_c();
        @(negedge clk); start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0;
    endtask

    task automatic stop_c();
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); byte_vld = 1'b1; byte_data = b;
        @(negedge clk); byte_vld = 1'b0;
    endtask

    task automatic t_reset();
        chk(match, 0, "R1 match after reset");
        chk(rw_dir, 0, "R1 rw_dir after reset");
        chk(gc_flag, 0, "R1 gc_flag after reset");
        mode_10b = 1'b0;
        start_c(); send(8'h01);                       // address 0, read, default config
        chk(match, 1, "R1 default own address 0 matches");
        start_c(); send(8'h00);                       // general call, disabled by default
        chk(match, 0, "R1 general call off after reset");
    endtask

    task automatic t_seven();
        mode_10b = 1'b0;
        cfg(10'h3A5, 1'b0);                           // bits 9:7 set, low seven = 0x25
        start_c(); send({7'h25, 1'b1});
        chk(match, 1, "R2 7-bit read match");
        chk(rw_dir, 1, "R2 rw_dir read");
        @(negedge clk);
        chk(match, 0, "R11 pulse lasts one cycle");
        send({7'h25, 1'b1});
        chk(match, 0, "R11 byte after match ignored");
        start_c(); send({7'h25, 1'b0});
        chk(match, 1, "R2 7-bit write match");
        chk(rw_dir, 0, "R2 rw_dir write");
        start_c(); send({7'h24, 1'b1});
        chk(match, 0, "R2 wrong address no match");
        chk(rw_dir, 0, "R12 rw_dir holds on mismatch");
        send({7'h25, 1'b1});
        chk(match, 0, "R4 byte after mismatch ignored");
        stop_c(); send({7'h25, 1'b1});
        chk(match, 0, "R11 byte without START ignored");
    endtask

    task automatic t_ten();
        mode_10b = 1'b1;
        cfg(10'h2C7, 1'b0);
        start_c(); send(8'hF5);
        chk(match, 0, "R3 no match on header alone");
        send(8'hC7);
        chk(match, 1, "R3 10-bit match");
        chk(rw_dir, 1, "R3 rw_dir from header");
        start_c(); send(8'hF4); send(8'hC6);
        chk(match, 0, "R3 wrong low byte");
        start_c(); send(8'hF2); send(8'hC7);
        chk(match, 0, "R4 wrong header bits then correct low byte");
        start_c(); send(8'hF4); stop_c(); send(8'hC7);
        chk(match, 0, "R10 STOP between header and low byte");
        start_c(); send(8'hF4); send(8'hC7);
        chk(match, 1, "R3 10-bit write match");
        chk(rw_dir, 0, "R3 rw_dir write");
        start_c(); send({7'h47, 1'b0});               // a 7-bit form of the low bits
        send(8'hC7);
        chk(match, 0, "R3 7-bit form rejected in 10-bit mode");
    endtask

    task automatic t_gc();
        mode_10b = 1'b0;
        cfg(10'h025, 1'b1);
        start_c(); send({7'h25, 1'b1});               // make rw_dir 1 first
        start_c(); send(8'h00);
        chk(match, 1, "R5 general call match");
        chk(rw_dir, 0, "R5 general call rw_dir");
        chk(gc_flag, 1, "R5 gc_flag set");
        stop_c(); send(8'h4A);
        chk(gc_flag, 1, "R7 gc_flag sticky over STOP and bytes");
        start_c();
        chk(gc_flag, 0, "R7 START clears gc_flag");
        mode_10b = 1'b1;
        start_c(); send(8'h00);
        chk(match, 1, "R5 general call in 10-bit mode");
        chk(gc_flag, 1, "R5 gc_flag in 10-bit mode");
        mode_10b = 1'b0;
        cfg(10'h000, 1'b0);
        start_c(); send(8'h00);
        chk(match, 0, "R6 general call disabled");
        chk(gc_flag, 0, "R6 gc_flag stays clear");
        cfg(10'h000, 1'b1);
        start_c(); send(8'h00);
        chk(gc_flag, 1, "R5 0x00 seen as general call with own address 0");
        start_c();
    endtask

    task automatic t_lock();
        mode_10b = 1'b0;
        cfg(10'h025, 1'b0);
        @(negedge clk); cfg_wr = 1'b1; cfg_addr = 10'h011; cfg_gc_en = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
        start_c(); send({7'h11, 1'b0});
        chk(match, 0, "R8 locked address write ignored");
        start_c(); send({7'h25, 1'b0});
        chk(match, 1, "R8 old address still matches");
        start_c(); send(8'h00);
        chk(match, 0, "R8 locked general call enable ignored");
    endtask

    task automatic t_swrst();
        mode_10b = 1'b0;
        cfg(10'h025, 1'b1);
        start_c(); send(8'h00);
        chk(gc_flag, 1, "R9 setup gc_flag");
        @(negedge clk); sw_rst = 1'b1;
        @(negedge clk);
        chk(gc_flag, 0, "R9 sw_rst clears gc_flag");
        start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0; byte_vld = 1'b1; byte_data = {7'h25, 1'b0};
        @(negedge clk); byte_vld = 1'b0;
        chk(match, 0, "R9 no match during sw_rst");
        sw_rst = 1'b0;
        start_c(); @(negedge clk); sw_rst = 1'b1; @(negedge clk); sw_rst = 1'b0;
        send({7'h25, 1'b0});
        chk(match, 0, "R9 sw_rst idles after START");
    endtask

    task automatic t_prio();
        mode_10b = 1'b0;
        cfg(10'h025, 1'b0);
        @(negedge clk); start_evt = 1'b1; stop_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0; stop_evt = 1'b0;
        send({7'h25, 1'b1});
        chk(match, 0, "R10 STOP outranks START");
        @(negedge clk); start_evt = 1'b1; byte_vld = 1'b1; byte_data = {7'h25, 1'b1};
        @(negedge clk); start_evt = 1'b0; byte_vld = 1'b0;
        chk(match, 0, "R10 byte with START dropped");
        send({7'h25, 1'b1});
        chk(match, 1, "R10 next byte matches after START");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seven();
        t_ten();
        t_gc();
        t_lock();
        t_swrst();
        t_prio();
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule